// File: doc/BRIEF.md
# Single-wire bus master slot engine

This block is the master side of an open-drain single-wire bus. It turns a one-command-at-a-time request into precisely timed bus slots, measured in microseconds. Those microseconds come from an internal prescaler running off the system clock. The bus is only ever pulled low through `bus_drive_low`. The returning line level enters on `bus_level`. Four operations exist, selected by `cmd_op`:

- `2'b00` reset with presence detect
- `2'b01` byte write
- `2'b10` byte read
- `2'b11` byte touch, which writes and samples in one pass

A strong pullup can be requested for the tail of a write. The request takes effect only for the command that carries it.

The sequencer has four states:

- `SQ_IDLE`: waits for `cmd_start`. Transition *accept* leads to `SQ_LAUNCH`.
- `SQ_LAUNCH`: a single cycle that fires one slot. It arms the strong pullup before bit 7 when one was requested. Transition *fire* leads to `SQ_WAIT`.
- `SQ_WAIT`: waits for the slot to finish. On finish it takes one of four transitions:
  - *next bit* to `SQ_LAUNCH`
  - *reset done* to `SQ_IDLE`
  - *byte done* to `SQ_IDLE`
  - *to pullup* to `SQ_PULL`
- `SQ_PULL`: holds the strong pullup for the requested time. Transition *pullup over* leads to `SQ_IDLE`.

The slot timer has three states:

- `SL_IDLE`: transition *go* leads to `SL_LOW`.
- `SL_LOW`: transition *low over* leads to `SL_REL`.
- `SL_REL`: transition *slot over* leads back to `SL_IDLE`. The sample is taken inside `SL_REL`.

Notation used below: T = `CLK_PER_US`·`DELAY_COEF` clock cycles, which is one scaled microsecond. "Low for n" means `bus_drive_low` is high for exactly n·T consecutive cycles.

Top module: `swire_master`

## Requirements
- R1: A bit of value 1 in a write or touch is a slot low for 6 µs followed by 64 µs released.
- R2: A bit of value 0 in a write or touch is a slot low for 60 µs followed by 10 µs released.
- R3: A read slot is low for 6 µs and released for 64 µs. The line is sampled 9 µs after release.
- R4: A reset holds the line low for 500 µs. It then releases the line for 500 µs: the presence sample comes at 70 µs and 430 µs of recovery follows. `busy` is high for exactly 1 + 1000·T cycles.
- R5: After a reset, `presence` is 1 if the sampled line was low and 0 if it was high.
- R6: Bytes move least significant bit first. In a read, the sample of slot i lands in `rx_byte` bit i.
- R7: In a touch, a 1 bit is sent as a sampling write-1 slot and its sample replaces the bit. A 0 bit is sent as a write-0 slot and yields 0.
- R8: With a nonzero `pullup_us` on a write or touch, `pullup_en` rises when the low phase of bit 7 ends. It stays high for the rest of that slot plus `pullup_us` µs. It is never high while `bus_drive_low` is high.
- R9: A zero `pullup_us`, any read or reset, and any later command without its own request leave `pullup_en` low. The request is one-shot.
- R10: Every duration scales with `DELAY_COEF`. With a coefficient of 2, a write-0 low phase lasts 120·`CLK_PER_US` cycles.
- R11: `busy` rises the cycle after an accepted `cmd_start`. `done` is a single-cycle pulse in the first cycle with `busy` low. `rx_byte` and `presence` are valid with `done`.
- R12: A `cmd_start` while `busy` is high is ignored: no second operation and no second `done`.
- R13: After reset, `busy`, `done`, `bus_drive_low`, `pullup_en`, `presence` and `rx_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Command request, accepted when idle |
| cmd_op | input | 2 | Operation code (00 reset, 01 write, 10 read, 11 touch) |
| cmd_byte | input | 8 | Byte to write or touch |
| pullup_us | input | PU_W | Strong pullup time in µs, 0 for none |
| bus_level | input | 1 | Sensed bus level |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte read or touched |
| presence | output | 1 | A device answered the last reset |
| pullup_en | output | 1 | Strong pullup enable |
| bus_drive_low | output | 1 | Pull the bus low |

## Verification
The results fall due at different times:
- Slot lengths are complete at the release edge, exactly low·T cycles after the line went low.
- `rx_byte` and `presence` fall due in the cycle that carries `done`, which is one edge after the final slot or pullup phase.
- The pullup and busy windows close at that same edge.

The bench measures runs of `bus_drive_low`, `pullup_en`, `busy` and `done` with edge counters. It reads them only at the falling clock edge after `done` has been seen plus one more cycle, so every counter has absorbed the last edge. A behavioural bus device pulls the line for a fixed window that surrounds the 9 µs and 70 µs sample points. Only a sample taken inside the specified window returns the expected byte.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_TOUCH = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SK_W1,
        SK_W0,
        SK_RD,
        SK_RST
    } slot_kind_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_LOW,
        SL_REL
    } slot_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_PULL
    } seq_st_e;

endpackage

// File: rtl/swire_tick.sv
module swire_tick #(
    parameter int PRE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (PRE == 1) begin : g_direct
            logic unused_clr;
            assign unused_clr = clr;
            assign tick = 1'b1;
        end else begin : g_count
            localparam int PW = $clog2(PRE);
            logic [PW-1:0] cnt;

            assign tick = (cnt == PW'(PRE - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cnt <= '0;
                else if (clr)    cnt <= '0;
                else if (tick)   cnt <= '0;
                else             cnt <= cnt + 1'b1;
            end

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R10
        end
    endgenerate
endmodule

// File: rtl/swire_slot.sv
module swire_slot
    import swire_pkg::*;
#(
    parameter int LOW1_US    = 6,
    parameter int REL1_US    = 64,
    parameter int LOW0_US    = 60,
    parameter int REL0_US    = 10,
    parameter int RD_SMP_US  = 9,
    parameter int RST_LOW_US = 500,
    parameter int RST_SMP_US = 70,
    parameter int RST_REC_US = 430,
    parameter int CW         = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  slot_kind_e kind,
    input  logic       bus_level,
    output logic       drive_low,
    output logic       released,
    output logic       fin,
    output logic       smp
);
    localparam logic [CW-1:0] ONE = CW'(1);

    slot_st_e        st, nst;
    slot_kind_e      kind_q;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   low_len, rel_len, smp_at;
    logic            samples;
    logic            low_over, rel_over, smp_now;

    // durations of the latched slot kind
    always_comb begin
        unique case (kind_q)
            SK_W1: begin
                low_len = CW'(LOW1_US);    rel_len = CW'(REL1_US);
                smp_at  = CW'(RD_SMP_US);  samples = 1'b0;
            end
            SK_W0: begin
                low_len = CW'(LOW0_US);    rel_len = CW'(REL0_US);
                smp_at  = CW'(RD_SMP_US);  samples = 1'b0;
            end
            SK_RD: begin
                low_len = CW'(LOW1_US);    rel_len = CW'(REL1_US);
                smp_at  = CW'(RD_SMP_US);  samples = 1'b1;
            end
            SK_RST: begin
                low_len = CW'(RST_LOW_US);
                rel_len = CW'(RST_SMP_US + RST_REC_US);
                smp_at  = CW'(RST_SMP_US); samples = 1'b1;
            end
            default: begin
                low_len = CW'(LOW1_US);    rel_len = CW'(REL1_US);
                smp_at  = CW'(RD_SMP_US);  samples = 1'b0;
            end
        endcase
    end

    assign low_over = (st == SL_LOW) && tick && (cnt == low_len - ONE);
    assign rel_over = (st == SL_REL) && tick && (cnt == rel_len - ONE);
    assign smp_now  = (st == SL_REL) && tick && samples && (cnt == smp_at - ONE);

    // next state
    always_comb begin
        nst = st;
        unique case (st)
            SL_IDLE: if (go)       nst = SL_LOW;   // go
            SL_LOW:  if (low_over) nst = SL_REL;   // low over
            SL_REL:  if (rel_over) nst = SL_IDLE;  // slot over
            default:               nst = SL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SL_IDLE;
        else        st <= nst;
    end

    // datapath and sample register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= SK_W1;
            cnt    <= '0;
            smp    <= 1'b0;
        end else begin
            if (st == SL_IDLE && go) begin
                kind_q <= kind;
                cnt    <= '0;
            end else if (st != SL_IDLE && tick) begin
                cnt <= (low_over || rel_over) ? '0 : cnt + ONE;
            end
            if (smp_now) smp <= bus_level;
        end
    end

    assign drive_low = (st == SL_LOW);
    assign released  = (st == SL_REL);
    assign fin       = rel_over;

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_LOW) |-> (cnt < low_len));  // R1
    AST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st == SL_IDLE));  // R12
endmodule

// File: rtl/swire_seq.sv
module swire_seq
    import swire_pkg::*;
#(
    parameter int PU_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      opcode,
    input  logic [7:0]      tx_byte,
    input  logic [PU_W-1:0] pu_us,
    input  logic            tick,
    input  logic            slot_fin,
    input  logic            slot_rel,
    input  logic            smp,
    output logic            slot_go,
    output slot_kind_e      slot_kind,
    output logic            tick_clr,
    output logic            busy,
    output logic            done,
    output logic [7:0]      rx_byte,
    output logic            presence,
    output logic            pullup_en
);
    localparam logic [2:0] LAST_BIT = 3'd7;

    seq_st_e         st, nst;
    op_e             op_q;
    logic [7:0]      tx_q;
    logic [PU_W-1:0] pu_q;
    logic [PU_W-1:0] pcnt;
    logic [2:0]      bit_idx;
    logic [7:0]      rx_sh;
    logic            armed;
    logic            cur_bit;
    logic            got;
    logic            pull_over;

    assign cur_bit   = tx_q[bit_idx];
    assign got       = (op_q == OP_TOUCH && !cur_bit) ? 1'b0 : smp;
    assign pull_over = (st == SQ_PULL) && tick && (pcnt == pu_q - 1'b1);

    // slot kind for the current bit
    always_comb begin
        unique case (op_q)
            OP_RESET: slot_kind = SK_RST;
            OP_WRITE: slot_kind = cur_bit ? SK_W1 : SK_W0;
            OP_READ:  slot_kind = SK_RD;
            OP_TOUCH: slot_kind = cur_bit ? SK_RD : SK_W0;
            default:  slot_kind = SK_W1;
        endcase
    end

    // next state
    always_comb begin
        nst = st;
        unique case (st)
            SQ_IDLE:   if (start) nst = SQ_LAUNCH;        // accept
            SQ_LAUNCH: nst = SQ_WAIT;                     // fire
            SQ_WAIT: begin
                if (slot_fin) begin
                    if (op_q == OP_RESET)        nst = SQ_IDLE;    // reset done
                    else if (bit_idx != LAST_BIT) nst = SQ_LAUNCH; // next bit
                    else if (armed)              nst = SQ_PULL;    // to pullup
                    else                         nst = SQ_IDLE;    // byte done
                end
            end
            SQ_PULL:   if (pull_over) nst = SQ_IDLE;      // pullup over
            default:   nst = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= nst;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_RESET;
            tx_q     <= '0;
            pu_q     <= '0;
            pcnt     <= '0;
            bit_idx  <= '0;
            rx_sh    <= '0;
            armed    <= 1'b0;
            rx_byte  <= '0;
            presence <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= (st != SQ_IDLE) && (nst == SQ_IDLE);
            unique case (st)
                SQ_IDLE: if (start) begin
                    op_q    <= op_e'(opcode);
                    tx_q    <= tx_byte;
                    pu_q    <= pu_us;
                    bit_idx <= '0;
                    rx_sh   <= '0;
                    armed   <= 1'b0;
                end
                SQ_LAUNCH: begin
                    if (bit_idx == LAST_BIT && pu_q != '0 &&
                        (op_q == OP_WRITE || op_q == OP_TOUCH))
                        armed <= 1'b1;
                end
                SQ_WAIT: if (slot_fin) begin
                    if (op_q == OP_RESET) begin
                        presence <= !smp;
                    end else begin
                        rx_sh[bit_idx] <= got;
                        bit_idx        <= bit_idx + 1'b1;
                        if (bit_idx == LAST_BIT && op_q != OP_WRITE)
                            rx_byte <= {got, rx_sh[6:0]};
                        pcnt <= '0;
                    end
                end
                SQ_PULL: begin
                    if (tick) pcnt <= pcnt + 1'b1;
                    if (pull_over) armed <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign slot_go   = (st == SQ_LAUNCH);
    assign tick_clr  = slot_go || (st == SQ_WAIT && nst == SQ_PULL);
    assign busy      = (st != SQ_IDLE);
    assign pullup_en = (armed && slot_rel) || (st == SQ_PULL);

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);  // R11
    AST_READ_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == OP_READ || op_q == OP_RESET)) |-> !pullup_en);  // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));  // R12
endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int CLK_PER_US = 4,
    parameter int DELAY_COEF = 1,
    parameter int PU_W       = 16,
    parameter int LOW1_US    = 6,
    parameter int REL1_US    = 64,
    parameter int LOW0_US    = 60,
    parameter int REL0_US    = 10,
    parameter int RD_SMP_US  = 9,
    parameter int RST_LOW_US = 500,
    parameter int RST_SMP_US = 70,
    parameter int RST_REC_US = 430
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [1:0]      cmd_op,
    input  logic [7:0]      cmd_byte,
    input  logic [PU_W-1:0] pullup_us,
    input  logic            bus_level,
    output logic            busy,
    output logic            done,
    output logic [7:0]      rx_byte,
    output logic            presence,
    output logic            pullup_en,
    output logic            bus_drive_low
);
    localparam int PRE  = CLK_PER_US * DELAY_COEF;
    localparam int RSTR = RST_SMP_US + RST_REC_US;
    localparam int M1   = (LOW1_US > REL1_US) ? LOW1_US : REL1_US;
    localparam int M2   = (LOW0_US > REL0_US) ? LOW0_US : REL0_US;
    localparam int M3   = (RST_LOW_US > RSTR) ? RST_LOW_US : RSTR;
    localparam int M12  = (M1 > M2) ? M1 : M2;
    localparam int MAXD = (M12 > M3) ? M12 : M3;
    localparam int CW   = $clog2(MAXD + 1);

    logic       tick, tick_clr;
    logic       slot_go, slot_fin, slot_rel, smp;
    slot_kind_e slot_kind;

    swire_tick #(.PRE(PRE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    swire_slot #(
        .LOW1_US(LOW1_US), .REL1_US(REL1_US), .LOW0_US(LOW0_US),
        .REL0_US(REL0_US), .RD_SMP_US(RD_SMP_US), .RST_LOW_US(RST_LOW_US),
        .RST_SMP_US(RST_SMP_US), .RST_REC_US(RST_REC_US), .CW(CW)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go        (slot_go),
        .kind      (slot_kind),
        .bus_level (bus_level),
        .drive_low (bus_drive_low),
        .released  (slot_rel),
        .fin       (slot_fin),
        .smp       (smp)
    );

    swire_seq #(.PU_W(PU_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .opcode    (cmd_op),
        .tx_byte   (cmd_byte),
        .pu_us     (pullup_us),
        .tick      (tick),
        .slot_fin  (slot_fin),
        .slot_rel  (slot_rel),
        .smp       (smp),
        .slot_go   (slot_go),
        .slot_kind (slot_kind),
        .tick_clr  (tick_clr),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .presence  (presence),
        .pullup_en (pullup_en)
    );

    AST_PULL_NOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> !bus_drive_low);  // R8
    AST_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_low |-> busy);  // R11
endmodule

// File: tb/tb_swire_master.sv
module tb_swire_master;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int LIMIT      = 190000;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  tx;
        logic [7:0]  pu;
        logic [7:0]  resp;
        logic        pres;
        logic [7:0]  exp_rx;
        logic        exp_pres;
        logic [15:0] exp_pull;
        logic [15:0] exp_low;
    } vec_t;

    // op: 0 reset, 1 write, 2 read, 3 touch ; pull and low in microseconds
    localparam vec_t VECS [9] = '{
        '{2'd0, 8'h00, 8'd0,  8'h00, 1'b1, 8'h00, 1'b1, 16'd0,  16'd500},
        '{2'd0, 8'h00, 8'd0,  8'h00, 1'b0, 8'h00, 1'b0, 16'd0,  16'd500},
        '{2'd1, 8'hA5, 8'd0,  8'hFF, 1'b0, 8'h00, 1'b0, 16'd0,  16'd6},
        '{2'd1, 8'h35, 8'd20, 8'hFF, 1'b0, 8'h00, 1'b0, 16'd30, 16'd60},
        '{2'd2, 8'h00, 8'd0,  8'h3C, 1'b0, 8'h3C, 1'b0, 16'd0,  16'd6},
        '{2'd2, 8'h00, 8'd9,  8'h81, 1'b0, 8'h81, 1'b0, 16'd0,  16'd6},
        '{2'd3, 8'hF0, 8'd0,  8'h5A, 1'b0, 8'h50, 1'b0, 16'd0,  16'd6},
        '{2'd3, 8'hFF, 8'd15, 8'hC3, 1'b0, 8'hC3, 1'b0, 16'd79, 16'd6},
        '{2'd1, 8'h80, 8'd0,  8'hFF, 1'b0, 8'h00, 1'b0, 16'd0,  16'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] tx = 8'h00;
    logic [15:0] pu = 16'd0;
    logic busy, done, presence, pullup_en, drv_low;
    logic [7:0] rx_byte;
    logic bus_level;

    logic start2 = 1'b0;
    logic busy2, done2, pres2, pull2, drv2;
    logic [7:0] rx2;

    int n_total = 0;
    int n_bad = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    // bench bus device and measurement state
    logic       clr_mon = 1'b0;
    logic [7:0] resp_byte = 8'hFF;
    logic       resp_present = 1'b0;
    logic [2:0] resp_idx = 3'd0;
    int pull_cnt = 0, delay_cnt = 0;
    int low_run = 0, last_low = 0, prev_low = 0;
    int pr_run = 0, pr_max = 0, b_run = 0, b_max = 0, done_cnt = 0;
    int low2_run = 0, first_low2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_level = !(drv_low || (pull_cnt != 0));

    swire_master dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(start), .cmd_op(op),
        .cmd_byte(tx), .pullup_us(pu), .bus_level(bus_level),
        .busy(busy), .done(done), .rx_byte(rx_byte), .presence(presence),
        .pullup_en(pullup_en), .bus_drive_low(drv_low)
    );

    swire_master #(.DELAY_COEF(2)) dut2 (
        .clk(clk), .rst_n(rst_n), .cmd_start(start2), .cmd_op(2'd1),
        .cmd_byte(8'h00), .pullup_us(16'd0), .bus_level(1'b1),
        .busy(busy2), .done(done2), .rx_byte(rx2), .presence(pres2),
        .pullup_en(pull2), .bus_drive_low(drv2)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (pull_cnt > 0) pull_cnt <= pull_cnt - 1;
        if (delay_cnt > 0) begin
            delay_cnt <= delay_cnt - 1;
            if (delay_cnt == 1) pull_cnt <= 100 * P;
        end
        if (drv_low) low_run <= low_run + 1;
        else         low_run <= 0;
        if (!drv_low && prev_low != 0) begin
            last_low <= low_run;
            if (low_run >= 400 * P) begin
                if (resp_present) delay_cnt <= 20 * P;
            end else begin
                if (low_run < 30 * P && !resp_byte[resp_idx]) pull_cnt <= 20 * P;
                resp_idx <= resp_idx + 3'd1;
            end
        end
        prev_low <= drv_low ? 1 : 0;
        if (drv2) low2_run <= low2_run + 1;
        else begin
            low2_run <= 0;
            if (low2_run != 0 && first_low2 == 0) first_low2 <= low2_run;
        end
        if (clr_mon) begin
            resp_idx <= 3'd0;
            pr_run <= 0; pr_max <= 0; b_run <= 0; b_max <= 0; done_cnt <= 0;
        end else begin
            if (pullup_en) begin
                pr_run <= pr_run + 1;
                if (pr_run + 1 > pr_max) pr_max <= pr_run + 1;
            end else pr_run <= 0;
            if (busy) begin
                b_run <= b_run + 1;
                if (b_run + 1 > b_max) b_max <= b_run + 1;
            end else b_run <= 0;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (cycles > LIMIT && !timed_out) begin
            timed_out = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog: run hung act=%0d exp<%0d", cycles, LIMIT);
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] b, input logic [15:0] d,
                          input logic [7:0] rsp, input logic prs, input bit mid_start);
        @(negedge clk);
        clr_mon = 1'b1;
        resp_byte = rsp;
        resp_present = prs;
        @(negedge clk);
        clr_mon = 1'b0;
        op = o; tx = b; pu = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (300) @(negedge clk);
            op = 2'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && !timed_out) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 reset outputs",
            {busy, done, drv_low, pullup_en, presence, rx_byte}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13 idle after reset", {busy, drv_low, pullup_en}, 0);

        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            run_op(v.op, v.tx, {8'd0, v.pu}, v.resp, v.pres, 1'b0);
            chk("R11 single done pulse", done_cnt, 1);
            case (v.op)
                2'd0: begin
                    chk("R4 reset low length", last_low, int'(v.exp_low) * P);
                    chk("R5 presence", int'(presence), int'(v.exp_pres));
                end
                2'd2: begin
                    chk("R3 read slot low", last_low, int'(v.exp_low) * P);
                    chk("R6 read byte lsb first", int'(rx_byte), int'(v.exp_rx));
                end
                2'd3: begin
                    chk(v.tx[7] ? "R1 touch last low" : "R2 touch last low",
                        last_low, int'(v.exp_low) * P);
                    chk("R7 touch byte", int'(rx_byte), int'(v.exp_rx));
                end
                default:
                    chk(v.tx[7] ? "R1 write-1 low" : "R2 write-0 low",
                        last_low, int'(v.exp_low) * P);
            endcase
            chk((v.exp_pull != 0) ? "R8 pullup window" : "R9 no pullup",
                pr_max, int'(v.exp_pull) * P);
        end

        // R4: busy spans launch plus full reset slot
        run_op(2'd0, 8'h00, 16'd0, 8'h00, 1'b1, 1'b0);
        chk("R4 reset busy length", b_max, 1 + 1000 * P);

        // R12: start during busy is ignored
        run_op(2'd1, 8'h00, 16'd0, 8'hFF, 1'b0, 1'b1);
        repeat (50) @(negedge clk);
        chk("R12 ignored start done count", done_cnt, 1);
        chk("R12 idle after ignored start", int'(busy), 0);

        // R10: coefficient of 2 doubles the write-0 low phase
        @(negedge clk);
        start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        while (!done2 && !timed_out) @(negedge clk);
        chk("R10 scaled write-0 low", first_low2, 120 * P);

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule